// File: doc/BRIEF.md
# Dual-Path Clock Source Slice Controller

This block is the control logic for one clock root slice. The slice has two parallel source paths, A and B. Each path has an 8-way source select, an enable gate and a pre-divider. A two-way final selector chooses between the paths, and one post-divider follows it. The block is modelled with clock enables. Each candidate source appears as a one-cycle `src_tick` pulse plus a `src_run` level that says the source is alive. The slice's output is the enable pulse `clk_en_out`.

A new source index is never applied to the live path. The index is loaded into the idle (spare) path and that path is gated on. The block then waits for the target source to tick twice, flips the final selector and gates off the path it left. The abandoned path keeps its old index. Writing the same index a second time brings both paths onto the same source, with only one of them gated. If the target source drops its `src_run` indication during the wait, the swap is abandoned and a sticky stall flag is raised. Divider ratios written by software wait as pending values and are applied only when an output period ends.

The parameter `HAS_PRE` selects the core variant (0), which has no pre-dividers.

Top module: `dual_path_slice`

## Requirements
- R1: After reset both selects are 0, path A is live (`live_b`=0), `gate_a`=1, `gate_b`=0, `busy`=0, `stall_err`=0, and both ratios read 0 (divide by 1).
- R2: A `sel_wr` accepted while idle takes effect on the next clock edge. At that edge the spare path's select takes `sel_idx`, its gate turns on, `busy` rises, `stall_err` clears and the live selector does not move.
- R3: The live selector changes only when a swap completes. At that edge `live_b` moves to the former spare path, the former live path is gated off and `busy` falls.
- R4: A swap completes on the clock edge that samples the second `src_tick` pulse of the target source counted after the write was accepted. Cycles without a tick do not advance it.
- R5: A `sel_wr` while `busy`=1 is ignored: neither select changes because of it.
- R6: If the target source has `src_run`=0 in any busy cycle, the next edge ends the swap. The spare path is gated off, `busy` falls, `stall_err` is set and stays set until the next accepted write, and `live_b` is unchanged.
- R7: Whenever `busy`=0, exactly one gate is on, and it is the gate of the live path.
- R8: Writing the same index twice in a row, each time letting the swap complete, leaves `sel_a` equal to `sel_b` with only the live path gated.
- R9: `clk_en_out` pulses only in a cycle where the live path's source ticks. Each gated path's pre-divider passes every (pre+1)-th tick of its source. The post-divider passes every (post+1)-th pre-divided tick of the live path. A counter at or above its ratio wraps on its next input tick.
- R10: `div_wr` stores pending ratios, 3-bit pre and 6-bit post. `pre_ratio` and `post_ratio` change only on a cycle with `clk_en_out`=1, and then take the pending values. A `div_wr` in that same cycle is included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Request a source change |
| sel_idx | input | 3 | Requested source index |
| div_wr | input | 1 | Write pending divider ratios |
| div_pre | input | 3 | Pre-divider ratio (divide by value+1) |
| div_post | input | 6 | Post-divider ratio (divide by value+1) |
| src_run | input | 8 | Per-source running indication |
| src_tick | input | 8 | Per-source clock-enable pulse |
| sel_a | output | 3 | Source index of path A |
| sel_b | output | 3 | Source index of path B |
| gate_a | output | 1 | Path A gate enable |
| gate_b | output | 1 | Path B gate enable |
| live_b | output | 1 | Final selector: 1 = path B live |
| busy | output | 1 | Swap in progress |
| stall_err | output | 1 | Last swap aborted on a stopped source |
| pre_ratio | output | 3 | Applied pre-divider ratio |
| post_ratio | output | 6 | Applied post-divider ratio |
| clk_en_out | output | 1 | Slice output clock enable |

## Verification
The first swap uses a target source that ticks only every third cycle. This separates counting ticks from counting cycles. A repeated write of the same index shows that both paths converge. A write issued one cycle into a swap shows that held-off writes do not corrupt the spare select. A target marked not running separates the abort path from the completion path. A divider phase with continuous ticks, then ratio writes landing mid-period, shows whether new ratios wait for the period boundary. A long random phase then mixes sparse ticks, occasional stopped sources, and writes of both kinds, compared cycle by cycle against a behavioural model.

// File: rtl/dual_path_slice.sv
module dual_path_slice #(
  parameter int NSRC    = 8,
  parameter int PREW    = 3,
  parameter int POSTW   = 6,
  parameter int SETTLE  = 2,
  parameter bit HAS_PRE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_wr,
  input  logic [$clog2(NSRC)-1:0] sel_idx,
  input  logic                    div_wr,
  input  logic [PREW-1:0]         div_pre,
  input  logic [POSTW-1:0]        div_post,
  input  logic [NSRC-1:0]         src_run,
  input  logic [NSRC-1:0]         src_tick,
  output logic [$clog2(NSRC)-1:0] sel_a,
  output logic [$clog2(NSRC)-1:0] sel_b,
  output logic                    gate_a,
  output logic                    gate_b,
  output logic                    live_b,
  output logic                    busy,
  output logic                    stall_err,
  output logic [PREW-1:0]         pre_ratio,
  output logic [POSTW-1:0]        post_ratio,
  output logic                    clk_en_out
);
  localparam int SW = $clog2(NSRC);
  localparam int CW = $clog2(SETTLE + 1);

  logic [1:0][SW-1:0] sel_q;
  logic [1:0]         gate_q;
  logic               live_q, busy_q, stall_q;
  logic [CW-1:0]      wait_q;
  logic [PREW-1:0]    pre_q, pre_pend;
  logic [POSTW-1:0]   post_q, post_pend, post_cnt;
  logic [1:0]         ptick;

  wire          spare    = ~live_q;
  wire [SW-1:0] tgt      = sel_q[spare];
  wire          accept   = sel_wr & ~busy_q;
  wire          live_tk  = ptick[live_q];
  wire          out_en   = live_tk & (post_cnt >= post_q);
  wire [PREW-1:0]  pre_eff  = div_wr ? div_pre  : pre_pend;
  wire [POSTW-1:0] post_eff = div_wr ? div_post : post_pend;

  for (genvar g = 0; g < 2; g++) begin : g_path
    wire raw = gate_q[g] & src_tick[sel_q[g]];
    if (HAS_PRE) begin : g_pre
      logic [PREW-1:0] cnt;
      assign ptick[g] = raw & (cnt >= pre_q);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)   cnt <= '0;
        else if (raw) cnt <= ptick[g] ? '0 : cnt + 1'b1;
    end else begin : g_nopre
      assign ptick[g] = raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      gate_q  <= 2'b01;
      live_q  <= 1'b0;
      busy_q  <= 1'b0;
      stall_q <= 1'b0;
      wait_q  <= '0;
    end else if (accept) begin
      sel_q[spare]  <= sel_idx;
      gate_q[spare] <= 1'b1;
      busy_q        <= 1'b1;
      stall_q       <= 1'b0;
      wait_q        <= '0;
    end else if (busy_q) begin
      if (!src_run[tgt]) begin
        gate_q[spare] <= 1'b0;
        busy_q        <= 1'b0;
        stall_q       <= 1'b1;
      end else if (src_tick[tgt]) begin
        if (wait_q == CW'(SETTLE - 1)) begin
          gate_q[live_q] <= 1'b0;
          live_q         <= spare;
          busy_q         <= 1'b0;
        end else begin
          wait_q <= wait_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      post_q    <= '0;
      pre_pend  <= '0;
      post_pend <= '0;
      post_cnt  <= '0;
    end else begin
      pre_pend  <= pre_eff;
      post_pend <= post_eff;
      if (live_tk) post_cnt <= out_en ? '0 : post_cnt + 1'b1;
      if (out_en) begin
        pre_q  <= HAS_PRE ? pre_eff : '0;
        post_q <= post_eff;
      end
    end
  end

  assign sel_a      = sel_q[0];
  assign sel_b      = sel_q[1];
  assign gate_a     = gate_q[0];
  assign gate_b     = gate_q[1];
  assign live_b     = live_q;
  assign busy       = busy_q;
  assign stall_err  = stall_q;
  assign pre_ratio  = pre_q;
  assign post_ratio = post_q;
  assign clk_en_out = out_en;
endmodule

// File: rtl/dual_path_slice_chk.sv
module dual_path_slice_chk #(
  parameter int NSRC  = 8,
  parameter int PREW  = 3,
  parameter int POSTW = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_wr,
  input logic [$clog2(NSRC)-1:0] sel_idx,
  input logic [NSRC-1:0]         src_run,
  input logic [NSRC-1:0]         src_tick,
  input logic [$clog2(NSRC)-1:0] sel_a,
  input logic [$clog2(NSRC)-1:0] sel_b,
  input logic                    gate_a,
  input logic                    gate_b,
  input logic                    live_b,
  input logic                    busy,
  input logic                    stall_err,
  input logic [PREW-1:0]         pre_ratio,
  input logic [POSTW-1:0]        post_ratio,
  input logic                    clk_en_out
);
  localparam int SW = $clog2(NSRC);
  wire [SW-1:0] spare_sel = live_b ? sel_a : sel_b;
  wire [SW-1:0] live_sel  = live_b ? sel_b : sel_a;
  wire          spare_g   = live_b ? gate_a : gate_b;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr && !busy |=> busy && spare_g && !stall_err && $stable(live_b)
                        && spare_sel == $past(sel_idx));

  p_live_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_b != $past(live_b) |-> $past(busy) && !busy);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sel_wr |=> $stable(sel_a) && $stable(sel_b));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !src_run[spare_sel] |=> stall_err && !busy && $stable(live_b));

  p_one_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $countones({gate_a, gate_b}) == 1 && (live_b ? gate_b : gate_a));

  p_out_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> src_tick[live_sel]);

  p_ratio_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clk_en_out) |-> $stable(pre_ratio) && $stable(post_ratio));
endmodule

bind dual_path_slice dual_path_slice_chk #(.NSRC(NSRC), .PREW(PREW), .POSTW(POSTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_idx(sel_idx),
  .src_run(src_run), .src_tick(src_tick), .sel_a(sel_a), .sel_b(sel_b),
  .gate_a(gate_a), .gate_b(gate_b), .live_b(live_b), .busy(busy),
  .stall_err(stall_err), .pre_ratio(pre_ratio), .post_ratio(post_ratio),
  .clk_en_out(clk_en_out));

// File: tb/test_dual_path_slice.sv
module test_dual_path_slice;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_wr = 0, div_wr = 0;
  logic [2:0] sel_idx = 0, div_pre = 0;
  logic [5:0] div_post = 0;
  logic [7:0] src_run = 8'hFF, src_tick = 8'h00;
  logic [2:0] sel_a, sel_b, pre_ratio;
  logic [5:0] post_ratio;
  logic gate_a, gate_b, live_b, busy, stall_err, clk_en_out;

  always #4 clk = ~clk;

  dual_path_slice i_dual_path_slice (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R1";

  int msel[2], mgate[2], mpcnt[2];
  int mlive, mbusy, mstall, mwait, mpre, mpost, mppend, mopend, mpostc;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    msel = '{0, 0}; mgate = '{1, 0}; mpcnt = '{0, 0};
    mlive = 0; mbusy = 0; mstall = 0; mwait = 0;
    mpre = 0; mpost = 0; mppend = 0; mopend = 0; mpostc = 0;
  endtask

  task automatic step();
    bit raw[2], pt[2], lt, out;
    int spare, tgt, pe, oe;
    longint exp_v, act_v;
    #1;
    for (int g = 0; g < 2; g++) begin
      raw[g] = mgate[g] != 0 && src_tick[msel[g]];
      pt[g]  = raw[g] && mpcnt[g] >= mpre;
    end
    lt  = pt[mlive];
    out = lt && mpostc >= mpost;
    exp_v = {3'(msel[0]), 3'(msel[1]), 1'(mgate[0]), 1'(mgate[1]), 1'(mlive),
             1'(mbusy), 1'(mstall), 3'(mpre), 6'(mpost), out};
    act_v = {sel_a, sel_b, gate_a, gate_b, live_b, busy, stall_err,
             pre_ratio, post_ratio, clk_en_out};
    check(phase, act_v, exp_v);
    for (int g = 0; g < 2; g++)
      if (raw[g]) mpcnt[g] = pt[g] ? 0 : mpcnt[g] + 1;
    if (lt) mpostc = out ? 0 : mpostc + 1;
    pe = div_wr ? int'(div_pre) : mppend;
    oe = div_wr ? int'(div_post) : mopend;
    mppend = pe; mopend = oe;
    if (out) begin mpre = pe; mpost = oe; end
    spare = 1 - mlive;
    if (sel_wr && !mbusy) begin
      msel[spare] = sel_idx; mgate[spare] = 1; mbusy = 1; mwait = 0; mstall = 0;
    end else if (mbusy) begin
      tgt = msel[spare];
      if (!src_run[tgt]) begin
        mgate[spare] = 0; mbusy = 0; mstall = 1;
      end else if (src_tick[tgt]) begin
        if (mwait == 1) begin mgate[mlive] = 0; mlive = spare; mbusy = 0; end
        else mwait++;
      end
    end
    @(negedge clk);
  endtask

  task automatic write_sel(int idx);
    sel_wr = 1; sel_idx = 3'(idx); step(); sel_wr = 0;
  endtask

  task automatic run_until_idle();
    for (int k = 0; k < 50 && busy; k++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 sels", {sel_a, sel_b}, 0);
    check("R1 gates", {gate_a, gate_b, live_b, busy, stall_err}, 5'b10000);
    check("R1 ratios", {pre_ratio, post_ratio}, 0);
    rst_n = 1;
    @(negedge clk);

    phase = "R2 R4 sparse-tick swap";
    write_sel(3);
    check("R2 spare loaded", {sel_b, gate_b, busy, live_b}, {3'd3, 3'b110});
    for (int k = 0; k < 12; k++) begin
      src_tick = (k % 3 == 2) ? 8'h08 : 8'h00;
      step();
    end
    src_tick = 0;
    check("R3 R4 swapped", {live_b, gate_a, gate_b, busy, sel_a, sel_b},
          {4'b1010, 3'd0, 3'd3});

    phase = "R8 repeat write";
    src_tick = 8'hFF;
    write_sel(3);
    run_until_idle();
    check("R8 aligned", {sel_a, sel_b, live_b, gate_a, gate_b}, {3'd3, 3'd3, 3'b010});

    phase = "R5 busy write";
    write_sel(5);
    write_sel(6);
    run_until_idle();
    check("R5 held off", {sel_a, sel_b, live_b}, {3'd3, 3'd5, 1'b1});

    phase = "R6 stall";
    src_run = 8'h7F;
    write_sel(7);
    step(); step();
    check("R6 aborted", {stall_err, busy, live_b, gate_a, gate_b}, 5'b10101);
    src_run = 8'hFF;
    write_sel(2);
    check("R6 cleared", stall_err, 0);
    run_until_idle();

    phase = "R9 R10 dividers";
    div_wr = 1; div_pre = 2; div_post = 3; step(); div_wr = 0;
    for (int k = 0; k < 60; k++) begin
      if (k == 17) begin div_wr = 1; div_pre = 1; div_post = 2; end
      step();
      div_wr = 0;
    end
    check("R10 applied", {pre_ratio, post_ratio}, {3'd1, 6'd2});

    phase = "R7 random";
    for (int k = 0; k < 4000; k++) begin
      src_tick = 8'($urandom);
      src_run  = ($urandom % 16 == 0) ? ~(8'd1 << ($urandom % 8)) : 8'hFF;
      sel_wr   = ($urandom % 8 == 0);
      sel_idx  = 3'($urandom);
      div_wr   = ($urandom % 32 == 0);
      div_pre  = 3'($urandom);
      div_post = 6'($urandom % 5);
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule